// File: doc/BRIEF.md
# Dual Cascadable Interval Timers

This block holds two 16-bit down-counters that a processor reaches through an eight-byte register window. A one-cycle enable, pulsed once per microsecond by the surrounding chip, is the time base. Each counter has a reload register that software loads one byte at a time. Each counter also has a control register that starts it, picks continuous or single-shot operation, and can force an immediate reload. The second counter can be chained so that it counts underflows of the first instead of time-base pulses. The two together then give a 32-bit period.

Every underflow sets a sticky flag in the interrupt register. A read of that register returns the flags and clears them. Software sets or clears the interrupt enables with a mask write. The `irq` output is high while any flag is pending and enabled.

Register offsets: 0 and 1 hold counter A (low byte, high byte). 2 and 3 hold counter B (low byte, high byte). 4 is reserved. 5 is the interrupt register. 6 is control A. 7 is control B.

A counter "underflows" when it receives a count event while it holds zero. The count event is a time-base pulse or, for a chained B, an A underflow. On underflow the counter takes the reload value, so the period is reload+1 events.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters, reload values, controls, flags and enables are zero, and `irq` is low. Every register reads 0x00 except offset 4, which reads 0xFF.
- R2: A write to a counter's low byte (offset 0 or 2) only latches that byte, and the counter does not change. A write to the high byte (offset 1 or 3) sets the reload value to {high, latched low}. If the timer is stopped, the same write also loads that value into the counter, which reads back at once.
- R3: While a timer is started, a high-byte write changes only the reload value. The counter keeps counting from its current value and takes the new value at its next underflow.
- R4: A started counter decrements by one per count event. A count event that finds it at zero sets its flag and loads the reload value.
- R5: A control bit 3 of 1 selects one-shot mode, and bit 0 is START. In one-shot mode an underflow clears START, so later count events leave the counter unchanged.
- R6: Writing control bit 4 as 1 copies the reload value into the counter in that cycle. Bit 4 always reads back 0.
- R7: Control B bits [6:5] pick B's count source: 0 selects time-base pulses, 2 selects counter A underflows, and 1 or 3 selects no events.
- R8: The interrupt register (offset 5) reads bit 0 = A flag, bit 1 = B flag, and bit 7 = some flag is pending with its enable set. Bits 6:2 read 0. A read clears both flags.
- R9: A write to offset 5 with bit 7 = 1 sets the enables chosen by bits [1:0]. With bit 7 = 0 it clears them. Other enables are unchanged.
- R10: `irq` is high exactly while some pending flag has its enable set.
- R11: Offset 4 always reads 0xFF, and writes to it change nothing.
- R12: An underflow in the same cycle as an interrupt-register read still leaves its flag set after the read. The read returns the flags as they stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle time-base pulse (1 µs) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
An underflow setting a flag can coincide with a processor read that clears the flags. The bench runs counter A with reload zero, so that every time-base pulse underflows, and raises `tick_en` and an interrupt-register read in the same cycle. It checks that the read returns the flags as they stood before that cycle and that a second read shows the A flag still set. A second overlap is also covered: a high-byte write on a running counter. The bench checks that the count goes on undisturbed and that the new value appears only after the next underflow.

// File: rtl/dit_pkg.sv
// Shared constants for the dual interval timer: register offsets and
// control-bit positions. Assumes an 8-bit data bus and 3-bit offsets.
package dit_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NUM_T   = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFF_A_LO  = 3'd0,
        OFF_A_HI  = 3'd1,
        OFF_B_LO  = 3'd2,
        OFF_B_HI  = 3'd3,
        OFF_RSVD  = 3'd4,
        OFF_IRQ   = 3'd5,
        OFF_A_CTL = 3'd6,
        OFF_B_CTL = 3'd7
    } reg_off_e;

    localparam int CTL_START   = 0;
    localparam int CTL_ONESHOT = 3;
    localparam int CTL_FORCE   = 4;
    localparam int CTL_SRC_LSB = 5;
    localparam int IRQ_SET_BIT = 7;

    localparam logic [1:0] SRC_TICK  = 2'd0;
    localparam logic [1:0] SRC_CHAIN = 2'd2;

endpackage

// File: rtl/dit_timer_unit.sv
// One down-counter with byte-wide reload loading and START/one-shot/force
// control. Assumes at most one register access per cycle, so a high-byte
// write and a control write never arrive together. A count event that finds
// the counter at zero is an underflow: the reload value is taken.
module dit_timer_unit #(
    parameter int CNT_W = 16,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_evt,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_ctl,
    input  logic [DW-1:0]    ld_data,
    input  logic             ctl_start,
    input  logic             ctl_oneshot,
    input  logic             ctl_force,
    output logic [CNT_W-1:0] count,
    output logic             start,
    output logic             oneshot,
    output logic             uflow
);

    localparam int HI_W = CNT_W - DW;

    logic [DW-1:0]    lo_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] hi_word;
    logic             start_q;
    logic             oneshot_q;

    // Word formed by the high byte being written and the latched low byte.
    assign hi_word = {ld_data[HI_W-1:0], lo_q};
    // Underflow: started counter at zero receiving a count event.
    assign uflow   = count_evt && start_q && (count_q == '0);

    // Latch the low byte until the high byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)      lo_q <= '0;
        else if (wr_lo)  lo_q <= ld_data;
    end

    // Reload value is set by every high-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)      reload_q <= '0;
        else if (wr_hi)  reload_q <= hi_word;
    end

    // Counter: force-load, stopped direct load, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n)                        count_q <= '0;
        else if (wr_ctl && ctl_force)      count_q <= reload_q;
        else if (wr_hi && !start_q)        count_q <= hi_word;
        else if (count_evt && start_q) begin
            if (count_q == '0)             count_q <= reload_q;
            else                           count_q <= count_q - CNT_W'(1);
        end
    end

    // Control bits: software writes, one-shot underflow stops the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q   <= 1'b0;
            oneshot_q <= 1'b0;
        end else if (wr_ctl) begin
            start_q   <= ctl_start;
            oneshot_q <= ctl_oneshot;
        end else if (uflow && oneshot_q) begin
            start_q   <= 1'b0;
        end
    end

    assign count   = count_q;
    assign start   = start_q;
    assign oneshot = oneshot_q;

endmodule

// File: rtl/dit_irq_unit.sv
// Sticky underflow flags with read-to-clear, and enables changed by a
// set/clear mask write. A flag set in the same cycle as a clearing read
// survives. Assumes one strobe per source per underflow.
module dit_irq_unit #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_evt,
    input  logic         rd_clr,
    input  logic         wr_mask,
    input  logic         mask_set,
    input  logic [N-1:0] mask_bits,
    output logic [N-1:0] flags,
    output logic         irq
);

    logic [N-1:0] flags_q;
    logic [N-1:0] en_q;

    // Flags: cleared by a read, but new events in that cycle win.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (rd_clr ? '0 : flags_q) | src_evt;
    end

    // Enables: set or clear the bits named in the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)        en_q <= '0;
        else if (wr_mask)  en_q <= mask_set ? (en_q | mask_bits)
                                            : (en_q & ~mask_bits);
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & en_q);

endmodule

// File: rtl/dual_interval_timer.sv
// Top of the dual interval timer: address decode, counter B source choice,
// and the read multiplexer. Reads are combinational and a read's side effect
// (flag clear) occurs at the clock edge of the strobe cycle.
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int HI_W = CNT_W - DATA_W;

    reg_off_e           off;
    logic [CNT_W-1:0]   cnt_a, cnt_b;
    logic               start_a, start_b, oneshot_a, oneshot_b;
    logic               uflow_a, uflow_b;
    logic [NUM_T-1:0]   uflow;
    logic [NUM_T-1:0]   flags;
    logic [1:0]         src_b_q;
    logic               evt_b;

    assign off   = reg_off_e'(reg_addr);
    assign uflow = {uflow_b, uflow_a};

    // Store counter B count-source selection.
    always_ff @(posedge clk) begin
        if (!rst_n)                          src_b_q <= SRC_TICK;
        else if (reg_wr && off == OFF_B_CTL) src_b_q <= reg_wdata[CTL_SRC_LSB +: 2];
    end

    // Pick counter B's count event from its source selection.
    always_comb begin
        case (src_b_q)
            SRC_TICK:  evt_b = tick_en;
            SRC_CHAIN: evt_b = uflow_a;
            default:   evt_b = 1'b0;
        endcase
    end

    dit_timer_unit #(.CNT_W(CNT_W), .DW(DATA_W)) u_tmr_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_evt  (tick_en),
        .wr_lo      (reg_wr && off == OFF_A_LO),
        .wr_hi      (reg_wr && off == OFF_A_HI),
        .wr_ctl     (reg_wr && off == OFF_A_CTL),
        .ld_data    (reg_wdata),
        .ctl_start  (reg_wdata[CTL_START]),
        .ctl_oneshot(reg_wdata[CTL_ONESHOT]),
        .ctl_force  (reg_wdata[CTL_FORCE]),
        .count      (cnt_a),
        .start      (start_a),
        .oneshot    (oneshot_a),
        .uflow      (uflow_a)
    );

    dit_timer_unit #(.CNT_W(CNT_W), .DW(DATA_W)) u_tmr_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_evt  (evt_b),
        .wr_lo      (reg_wr && off == OFF_B_LO),
        .wr_hi      (reg_wr && off == OFF_B_HI),
        .wr_ctl     (reg_wr && off == OFF_B_CTL),
        .ld_data    (reg_wdata),
        .ctl_start  (reg_wdata[CTL_START]),
        .ctl_oneshot(reg_wdata[CTL_ONESHOT]),
        .ctl_force  (reg_wdata[CTL_FORCE]),
        .count      (cnt_b),
        .start      (start_b),
        .oneshot    (oneshot_b),
        .uflow      (uflow_b)
    );

    dit_irq_unit #(.N(NUM_T)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (uflow),
        .rd_clr   (reg_rd && off == OFF_IRQ),
        .wr_mask  (reg_wr && off == OFF_IRQ),
        .mask_set (reg_wdata[IRQ_SET_BIT]),
        .mask_bits(reg_wdata[NUM_T-1:0]),
        .flags    (flags),
        .irq      (irq)
    );

    // Read multiplexer over the eight offsets.
    always_comb begin
        reg_rdata = '0;
        case (off)
            OFF_A_LO:  reg_rdata = cnt_a[DATA_W-1:0];
            OFF_A_HI:  reg_rdata[HI_W-1:0] = cnt_a[CNT_W-1:DATA_W];
            OFF_B_LO:  reg_rdata = cnt_b[DATA_W-1:0];
            OFF_B_HI:  reg_rdata[HI_W-1:0] = cnt_b[CNT_W-1:DATA_W];
            OFF_RSVD:  reg_rdata = '1;
            OFF_IRQ: begin
                reg_rdata[NUM_T-1:0]  = flags;
                reg_rdata[IRQ_SET_BIT] = irq;
            end
            OFF_A_CTL: begin
                reg_rdata[CTL_START]   = start_a;
                reg_rdata[CTL_ONESHOT] = oneshot_a;
            end
            OFF_B_CTL: begin
                reg_rdata[CTL_START]          = start_b;
                reg_rdata[CTL_ONESHOT]        = oneshot_b;
                reg_rdata[CTL_SRC_LSB +: 2]   = src_b_q;
            end
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dit_checker.sv
// Temporal checks for the dual interval timer, attached by bind. Observes
// ports and the signals passed between the timer units and the flag logic.
module dit_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [2:0]       reg_addr,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [7:0]       reg_rdata,
    input logic             irq,
    input logic [1:0]       uflow,
    input logic             start_a,
    input logic             oneshot_a,
    input logic [CNT_W-1:0] cnt_a,
    input logic [1:0]       flags
);

    assert_rsvd_reads_ff_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd4) |-> (reg_rdata == 8'hFF));

    assert_force_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd6 || reg_addr == 3'd7) |-> !reg_rdata[4]);

    assert_oneshot_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow[0] && oneshot_a && !(reg_wr && reg_addr == 3'd6)) |=> !start_a);

    assert_running_hi_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_a && reg_wr && reg_addr == 3'd1 && !tick_en) |=> $stable(cnt_a));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 3'd5 && uflow == 2'b00) |=> (flags == 2'b00));

    assert_read_keeps_new_uflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow[0] && reg_rd && reg_addr == 3'd5) |=> flags[0]);

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|uflow || (reg_wr && reg_addr == 3'd5)));

endmodule

bind dual_interval_timer dit_checker #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .uflow    (uflow),
    .start_a  (start_a),
    .oneshot_a(oneshot_a),
    .cnt_a    (cnt_a),
    .flags    (flags)
);

// File: tb/dual_interval_timer_tb.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, interrupt masking and the read/underflow overlap.
module dual_interval_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dual_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [1:0] op;   // 0 write, 1 read-check, 2 ticks
        logic [2:0] ad;
        logic [7:0] d;
        logic [7:0] x;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 56;
    localparam vec_t VECS [NV] = '{
        '{2'd1,3'd6,8'h00,8'h00,4'd1},  // R1 control A idle
        '{2'd0,3'd0,8'h03,8'h00,4'd2},
        '{2'd1,3'd0,8'h00,8'h00,4'd2},  // R2 low byte only latched
        '{2'd0,3'd1,8'h00,8'h00,4'd2},
        '{2'd1,3'd0,8'h00,8'h03,4'd2},  // R2 stopped high write loads
        '{2'd0,3'd6,8'h01,8'h00,4'd4},
        '{2'd2,3'd0,8'd1, 8'h00,4'd4},
        '{2'd1,3'd0,8'h00,8'h02,4'd4},  // R4 decrement
        '{2'd2,3'd0,8'd2, 8'h00,4'd4},
        '{2'd1,3'd0,8'h00,8'h00,4'd4},
        '{2'd2,3'd0,8'd1, 8'h00,4'd4},
        '{2'd1,3'd0,8'h00,8'h03,4'd4},  // R4 underflow reloads
        '{2'd1,3'd5,8'h00,8'h01,4'd8},  // R8 flag A, no enable
        '{2'd1,3'd5,8'h00,8'h00,4'd8},  // R8 cleared by read
        '{2'd1,3'd4,8'h00,8'hFF,4'd11}, // R11
        '{2'd0,3'd4,8'h55,8'h00,4'd11},
        '{2'd1,3'd4,8'h00,8'hFF,4'd11}, // R11 write ignored
        '{2'd0,3'd0,8'h10,8'h00,4'd3},
        '{2'd0,3'd1,8'h00,8'h00,4'd3},
        '{2'd1,3'd0,8'h00,8'h03,4'd3},  // R3 running count kept
        '{2'd2,3'd0,8'd4, 8'h00,4'd3},
        '{2'd1,3'd0,8'h00,8'h10,4'd3},  // R3 new reload after underflow
        '{2'd0,3'd5,8'h81,8'h00,4'd9},
        '{2'd1,3'd5,8'h00,8'h81,4'd9},  // R9 enable A set, summary on
        '{2'd2,3'd0,8'd1, 8'h00,4'd4},
        '{2'd1,3'd0,8'h00,8'h0F,4'd4},
        '{2'd0,3'd6,8'h11,8'h00,4'd6},
        '{2'd1,3'd0,8'h00,8'h10,4'd6},  // R6 force load
        '{2'd1,3'd6,8'h00,8'h01,4'd6},  // R6 force bit reads 0
        '{2'd0,3'd6,8'h00,8'h00,4'd5},
        '{2'd0,3'd0,8'h01,8'h00,4'd5},
        '{2'd0,3'd1,8'h00,8'h00,4'd5},
        '{2'd0,3'd6,8'h09,8'h00,4'd5},
        '{2'd2,3'd0,8'd2, 8'h00,4'd5},
        '{2'd1,3'd6,8'h00,8'h08,4'd5},  // R5 START cleared
        '{2'd2,3'd0,8'd1, 8'h00,4'd5},
        '{2'd1,3'd0,8'h00,8'h01,4'd5},  // R5 no further count
        '{2'd0,3'd2,8'h01,8'h00,4'd7},
        '{2'd0,3'd3,8'h00,8'h00,4'd7},
        '{2'd0,3'd7,8'h41,8'h00,4'd7},
        '{2'd1,3'd7,8'h00,8'h41,4'd7},  // R7 chain source readback
        '{2'd2,3'd0,8'd1, 8'h00,4'd7},
        '{2'd1,3'd2,8'h00,8'h01,4'd7},  // R7 ticks ignored when chained
        '{2'd0,3'd6,8'h01,8'h00,4'd7},
        '{2'd2,3'd0,8'd2, 8'h00,4'd7},
        '{2'd1,3'd2,8'h00,8'h00,4'd7},  // R7 one A underflow counted
        '{2'd2,3'd0,8'd2, 8'h00,4'd7},
        '{2'd1,3'd2,8'h00,8'h01,4'd7},  // R7 B underflow and reload
        '{2'd1,3'd5,8'h00,8'h83,4'd8},  // R8 both flags, summary
        '{2'd0,3'd7,8'h01,8'h00,4'd7},
        '{2'd2,3'd0,8'd1, 8'h00,4'd7},
        '{2'd1,3'd2,8'h00,8'h00,4'd7},  // R7 tick source
        '{2'd0,3'd7,8'h21,8'h00,4'd7},
        '{2'd2,3'd0,8'd3, 8'h00,4'd7},
        '{2'd1,3'd2,8'h00,8'h00,4'd7},  // R7 source 1 counts nothing
        '{2'd1,3'd3,8'h00,8'h00,4'd2}   // R2 high byte of B
    };

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input int rq);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %02h expected %02h", rq, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: wr(VECS[i].ad, VECS[i].d);
                2'd1: begin
                    rd(VECS[i].ad, v);
                    check(v, VECS[i].x, int'(VECS[i].rq));
                end
                default: ticks(int'(VECS[i].d));
            endcase
        end

        // R1: reset returns every register to its idle value
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check({7'd0, irq}, 8'h00, 1);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check(v, (a == 4) ? 8'hFF : 8'h00, 1);
        end

        // R10 / R9: irq follows enabled pending flags
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        wr(3'd5, 8'h81);
        wr(3'd6, 8'h01);
        check({7'd0, irq}, 8'h00, 10);
        ticks(1);
        check({7'd0, irq}, 8'h01, 10);
        wr(3'd5, 8'h01);
        check({7'd0, irq}, 8'h00, 9);
        rd(3'd5, v);
        check(v, 8'h01, 9);

        // R12: underflow in the same cycle as an interrupt-register read
        @(negedge clk);
        reg_addr = 3'd5; reg_rd = 1'b1; tick_en = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; tick_en = 1'b0;
        check(v, 8'h00, 12);
        rd(3'd5, v);
        check(v, 8'h01, 12);

        // R10: enabling a pending flag raises irq
        ticks(1);
        wr(3'd5, 8'h81);
        check({7'd0, irq}, 8'h01, 10);

        finish_run();
    end

endmodule